// File: doc/BRIEF.md
# Splittable SIMD Integer ALU

This block is a 128-bit integer datapath made of two 64-bit halves. In split mode each half runs its own scalar 64-bit operation, chosen by its own opcode. In locked mode the two halves act as a single packed unit that splits the 128-bit operands into lanes of 8, 16 or 32 bits and applies one operation to every lane in the same cycle.

The operations are wrap-around add and subtract, signed min and max, absolute value, three shifts, bitwise logic, two compares, pack and sign or zero extend. The result and a byte-granular compare mask are registered once, so they appear one clock edge after the operands are presented. Multiply, divide, register storage and pipelining are left to the surrounding core.

Top module: `simd_split_alu`

## Requirements
- R1: While `rst_n` is low, and after it, until the first operation is registered, `res_o` and `flags_o` read zero.
- R2: The output is registered. Inputs applied before a rising edge show up on `res_o`/`flags_o` after that edge, and the outputs do not change between edges.
- R3: Add (opcode 0) and subtract (opcode 1) wrap modulo the lane width, and no carry or borrow crosses a lane boundary. In locked mode `lane_sel_i` picks the lane width for every operation: 0 gives 8 bits, 1 gives 16 bits, and 2 or 3 give 32 bits.
- R4: Min (opcode 2) and max (opcode 3) pick, per lane, the signed smaller or larger of the `a_i` and `b_i` lanes.
- R5: Absolute value (opcode 4) returns the magnitude of each `a_i` lane. The most negative lane value comes back unchanged, with no saturation.
- R6: Shift left logical (opcode 5), shift right logical (opcode 6) and shift right arithmetic (opcode 7) move each `a_i` lane by `shamt_i` modulo the lane width. Every lane uses the same amount. Bits that leave a lane are dropped, and the arithmetic shift fills with the lane's sign bit.
- R7: AND (opcode 8), OR (opcode 9) and XOR (opcode 10) act bitwise on the full operands.
- R8: Signed greater-than, a>b (opcode 11), and equality (opcode 12) set a lane to all ones when true and all zeros when false. Bit j of `flags_o` covers byte j of the result and equals its lane's outcome. `flags_o` is zero for every other opcode.
- R9: Pack (opcode 13) takes the low half of every `a_i` lane, in lane order, into the low half of the result, and the low half of every `b_i` lane into the high half. The selected width is the source lane width.
- R10: Sign extend (opcode 14) and zero extend (opcode 15) widen the lanes of half the selected width, taken in order from the low half of `a_i`, into lanes of the selected width.
- R11: With `split_i` high, bits 63:0 follow `op_lo_i` and bits 127:64 follow `op_hi_i`, each as one 64-bit lane. Pack then yields {b[31:0], a[31:0]} per half, and extend widens bits 31:0 of the half. `lane_sel_i` and `vec_op_i` have no effect. Flag bits 7:0 belong to the low half and bits 15:8 to the high half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| split_i | input | 1 | 1: two independent 64-bit operations; 0: one packed operation |
| lane_sel_i | input | 2 | Lane width in locked mode |
| vec_op_i | input | 4 | Opcode in locked mode |
| op_lo_i | input | 4 | Opcode of the low half in split mode |
| op_hi_i | input | 4 | Opcode of the high half in split mode |
| shamt_i | input | 6 | Shift amount shared by all lanes |
| a_i | input | 128 | First operand |
| b_i | input | 128 | Second operand |
| res_o | output | 128 | Registered result |
| flags_o | output | 16 | Registered per-byte compare mask |

## Verification
In split mode the two halves can run any pair of opcodes in the same cycle, for example a compare in one half next to a shift or pack in the other. That is where state or selection can leak between halves. The bench drives every one of the 256 opcode pairs with `lane_sel_i` and `vec_op_i` randomised. It judges each half separately against an arithmetic model of a single 64-bit lane, so a half that borrows the other's opcode, width or flags is caught. Locked mode is swept over every opcode and every lane width with boundary operands: most negative lanes, all ones, equal operands and zeros.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_MIN  = 4'd2,
        OP_MAX  = 4'd3,
        OP_ABS  = 4'd4,
        OP_SLL  = 4'd5,
        OP_SRL  = 4'd6,
        OP_SRA  = 4'd7,
        OP_AND  = 4'd8,
        OP_OR   = 4'd9,
        OP_XOR  = 4'd10,
        OP_CGT  = 4'd11,
        OP_CEQ  = 4'd12,
        OP_PACK = 4'd13,
        OP_EXTS = 4'd14,
        OP_EXTZ = 4'd15
    } alu_op_e;

    // operations handled by the lane-rearranging unit rather than the lane ALU
    function automatic logic is_rearrange(alu_op_e op);
        return (op == OP_PACK) || (op == OP_EXTS) || (op == OP_EXTZ);
    endfunction

    function automatic logic is_compare(alu_op_e op);
        return (op == OP_CGT) || (op == OP_CEQ);
    endfunction

    function automatic logic is_shift(alu_op_e op);
        return (op == OP_SLL) || (op == OP_SRL) || (op == OP_SRA);
    endfunction

endpackage

// File: rtl/simd_lane_unit.sv
// Element-wise integer unit: VEC_W bits cut into lanes of LANE_W bits.
module simd_lane_unit
    import simd_alu_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int VEC_W  = 128,
    parameter int SH_W   = $clog2(LANE_W)
) (
    input  alu_op_e            op_i,
    input  logic [VEC_W-1:0]   a_i,
    input  logic [VEC_W-1:0]   b_i,
    input  logic [SH_W-1:0]    shamt_i,
    output logic [VEC_W-1:0]   res_o,
    output logic [VEC_W/8-1:0] flag_o
);
    localparam int NLANE  = VEC_W / LANE_W;
    localparam int BPL    = LANE_W / 8;
    localparam logic [LANE_W-1:0] MOST_NEG = {1'b1, {(LANE_W-1){1'b0}}};

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        logic [LANE_W-1:0] la;
        logic [LANE_W-1:0] lb;
        logic [LANE_W-1:0] r;
        logic              gt;
        logic              eq;

        assign la = a_i[g*LANE_W +: LANE_W];
        assign lb = b_i[g*LANE_W +: LANE_W];
        assign gt = $signed(la) > $signed(lb);
        assign eq = (la == lb);

        always_comb begin
            unique case (op_i)
                OP_ADD:  r = la + lb;
                OP_SUB:  r = la - lb;
                OP_MIN:  r = gt ? lb : la;
                OP_MAX:  r = gt ? la : lb;
                OP_ABS:  r = la[LANE_W-1] ? (~la + 1'b1) : la;
                OP_SLL:  r = la << shamt_i;
                OP_SRL:  r = la >> shamt_i;
                OP_SRA:  r = $signed(la) >>> shamt_i;
                OP_AND:  r = la & lb;
                OP_OR:   r = la | lb;
                OP_XOR:  r = la ^ lb;
                OP_CGT:  r = {LANE_W{gt}};
                OP_CEQ:  r = {LANE_W{eq}};
                default: r = '0;
            endcase
            if (op_i == OP_ABS)
                AST_ABS_SIGN: assert (!r[LANE_W-1] || la == MOST_NEG); // R5
            if (op_i == OP_MIN)
                AST_MIN_PICK: assert (r == la || r == lb); // R4
        end

        assign res_o[g*LANE_W +: LANE_W] = r;
        assign flag_o[g*BPL +: BPL] =
            {BPL{((op_i == OP_CGT) && gt) || ((op_i == OP_CEQ) && eq)}};
    end

endmodule

// File: rtl/simd_pack_ext.sv
// Pack (narrow both operands) and sign/zero extend (widen low half of a).
module simd_pack_ext
    import simd_alu_pkg::*;
#(
    parameter int LANE_W = 16,
    parameter int VEC_W  = 128
) (
    input  alu_op_e          op_i,
    input  logic [VEC_W-1:0] a_i,
    input  logic [VEC_W-1:0] b_i,
    output logic [VEC_W-1:0] res_o
);
    localparam int NLANE = VEC_W / LANE_W;
    localparam int HW    = LANE_W / 2;
    localparam int HV    = VEC_W / 2;

    logic [VEC_W-1:0] packed_v;
    logic [VEC_W-1:0] sext_v;
    logic [VEC_W-1:0] zext_v;
    logic             unused_bits;

    assign unused_bits = ^{a_i, b_i};

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        assign packed_v[g*HW +: HW]      = a_i[g*LANE_W +: HW];
        assign packed_v[HV + g*HW +: HW] = b_i[g*LANE_W +: HW];
        assign sext_v[g*LANE_W +: LANE_W] =
            {{HW{a_i[g*HW + HW - 1]}}, a_i[g*HW +: HW]};
        assign zext_v[g*LANE_W +: LANE_W] = {{HW{1'b0}}, a_i[g*HW +: HW]};
    end

    always_comb begin
        unique case (op_i)
            OP_PACK: res_o = packed_v;
            OP_EXTS: res_o = sext_v;
            OP_EXTZ: res_o = zext_v;
            default: res_o = '0;
        endcase
    end

endmodule

// File: rtl/simd_split_alu.sv
module simd_split_alu
    import simd_alu_pkg::*;
#(
    parameter int HALF_W = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      split_i,
    input  logic [1:0]                lane_sel_i,
    input  logic [3:0]                vec_op_i,
    input  logic [3:0]                op_lo_i,
    input  logic [3:0]                op_hi_i,
    input  logic [$clog2(HALF_W)-1:0] shamt_i,
    input  logic [2*HALF_W-1:0]       a_i,
    input  logic [2*HALF_W-1:0]       b_i,
    output logic [2*HALF_W-1:0]       res_o,
    output logic [HALF_W/4-1:0]       flags_o
);
    localparam int VEC_W = 2 * HALF_W;
    localparam int NBYTE = VEC_W / 8;
    localparam int HBYTE = HALF_W / 8;
    localparam int NSIZE = 3;

    typedef struct packed {
        logic [VEC_W-1:0] res;
        logic [NBYTE-1:0] flg;
    } alu_out_t;

    alu_out_t nxt_d, cur_q;
    alu_op_e  vec_op;
    alu_op_e  half_op  [2];
    logic [1:0] sz;

    logic [VEC_W-1:0]  lane_res [NSIZE];
    logic [VEC_W-1:0]  pe_res   [NSIZE];
    logic [NBYTE-1:0]  lane_flg [NSIZE];
    logic [HALF_W-1:0] half_res [2];
    logic [HALF_W-1:0] half_pe  [2];
    logic [HBYTE-1:0]  half_flg [2];

    assign vec_op = alu_op_e'(vec_op_i);
    assign sz     = (lane_sel_i == 2'd3) ? 2'd2 : lane_sel_i;

    // locked mode: one lane unit and one pack/extend unit per lane width
    for (genvar k = 0; k < NSIZE; k++) begin : g_size
        localparam int LW  = 8 << k;
        localparam int LSH = $clog2(LW);
        simd_lane_unit #(.LANE_W(LW), .VEC_W(VEC_W), .SH_W(LSH)) u_lane (
            .op_i    (vec_op),
            .a_i     (a_i),
            .b_i     (b_i),
            .shamt_i (shamt_i[LSH-1:0]),
            .res_o   (lane_res[k]),
            .flag_o  (lane_flg[k])
        );
        simd_pack_ext #(.LANE_W(LW), .VEC_W(VEC_W)) u_pe (
            .op_i  (vec_op),
            .a_i   (a_i),
            .b_i   (b_i),
            .res_o (pe_res[k])
        );
    end

    // split mode: each half is a single full-width lane with its own opcode
    for (genvar h = 0; h < 2; h++) begin : g_half
        assign half_op[h] = alu_op_e'((h == 0) ? op_lo_i : op_hi_i);
        simd_lane_unit #(.LANE_W(HALF_W), .VEC_W(HALF_W), .SH_W($clog2(HALF_W))) u_lane (
            .op_i    (half_op[h]),
            .a_i     (a_i[h*HALF_W +: HALF_W]),
            .b_i     (b_i[h*HALF_W +: HALF_W]),
            .shamt_i (shamt_i),
            .res_o   (half_res[h]),
            .flag_o  (half_flg[h])
        );
        simd_pack_ext #(.LANE_W(HALF_W), .VEC_W(HALF_W)) u_pe (
            .op_i  (half_op[h]),
            .a_i   (a_i[h*HALF_W +: HALF_W]),
            .b_i   (b_i[h*HALF_W +: HALF_W]),
            .res_o (half_pe[h])
        );
    end

    always_comb begin
        nxt_d = '0;
        if (split_i) begin
            for (int h = 0; h < 2; h++) begin
                nxt_d.res[h*HALF_W +: HALF_W] =
                    is_rearrange(half_op[h]) ? half_pe[h] : half_res[h];
                nxt_d.flg[h*HBYTE +: HBYTE] = half_flg[h];
            end
        end else begin
            nxt_d.res = is_rearrange(vec_op) ? pe_res[sz] : lane_res[sz];
            nxt_d.flg = lane_flg[sz];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign res_o   = cur_q.res;
    assign flags_o = cur_q.flg;

    // ---------------- assertions ----------------
    logic [VEC_W-1:0] flag_exp;
    for (genvar j = 0; j < NBYTE; j++) begin : g_fexp
        assign flag_exp[j*8 +: 8] = {8{flags_o[j]}};
    end

    AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!split_i && !is_compare(vec_op)) |=> (flags_o == '0)); // R8
    AST_CMP_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!split_i && is_compare(vec_op)) |=> (res_o == flag_exp)); // R8
    AST_EQ_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        (!split_i && vec_op == OP_CEQ && a_i == b_i) |=> (&flags_o)); // R8
    AST_SHIFT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!split_i && is_shift(vec_op) && shamt_i == '0) |=> (res_o == $past(a_i))); // R6
    AST_SPLIT_LO_EQ: assert property (@(posedge clk) disable iff (!rst_n)
        (split_i && half_op[0] == OP_CEQ && a_i[HALF_W-1:0] == b_i[HALF_W-1:0])
        |=> (&flags_o[HBYTE-1:0])); // R11

endmodule

// File: tb/sim_simd_split_alu.sv
module sim_simd_split_alu;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         split_i;
    logic [1:0]   lane_sel_i;
    logic [3:0]   vec_op_i, op_lo_i, op_hi_i;
    logic [5:0]   shamt_i;
    logic [127:0] a_i, b_i;
    logic [127:0] res_o;
    logic [15:0]  flags_o;

    int nchk  = 0;
    int nfail = 0;

    simd_split_alu u0 (
        .clk(clk), .rst_n(rst_n), .split_i(split_i), .lane_sel_i(lane_sel_i),
        .vec_op_i(vec_op_i), .op_lo_i(op_lo_i), .op_hi_i(op_hi_i),
        .shamt_i(shamt_i), .a_i(a_i), .b_i(b_i), .res_o(res_o), .flags_o(flags_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic string req_of(int op);
        case (op)
            0, 1:    return "R3";
            2, 3:    return "R4";
            4:       return "R5";
            5, 6, 7: return "R6";
            8, 9, 10: return "R7";
            11, 12:  return "R8";
            13:      return "R9";
            default: return "R10";
        endcase
    endfunction

    // arithmetic model of vw bits cut into lanes of w bits
    function automatic void ref_lanes(input int op, input int w, input int vw,
                                      input logic [127:0] a, input logic [127:0] b,
                                      input int sh, output logic [127:0] r,
                                      output logic [15:0] f);
        logic [63:0] mask, la, lb, lv;
        longint sa, sb;
        int hw, s;
        bit cond;
        r = '0; f = '0; hw = w / 2;
        mask = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
        s = sh % w;
        for (int i = 0; i < vw / w; i++) begin
            if (op == 13) begin
                for (int k = 0; k < hw; k++) begin
                    r[i*hw + k]        = a[i*w + k];
                    r[vw/2 + i*hw + k] = b[i*w + k];
                end
            end else if (op == 14 || op == 15) begin
                for (int k = 0; k < w; k++)
                    r[i*w + k] = (k < hw) ? a[i*hw + k]
                               : ((op == 14) ? a[i*hw + hw - 1] : 1'b0);
            end else begin
                la = 64'(a >> (i*w)) & mask;
                lb = 64'(b >> (i*w)) & mask;
                sa = la[w-1] ? longint'(la | ~mask) : longint'(la);
                sb = lb[w-1] ? longint'(lb | ~mask) : longint'(lb);
                cond = 1'b0;
                case (op)
                    0:  lv = la + lb;
                    1:  lv = la - lb;
                    2:  lv = (sa < sb) ? la : lb;
                    3:  lv = (sa > sb) ? la : lb;
                    4:  lv = (sa < 0) ? 64'(-sa) : la;
                    5:  lv = la << s;
                    6:  lv = la >> s;
                    7:  lv = 64'(sa >>> s);
                    8:  lv = la & lb;
                    9:  lv = la | lb;
                    10: lv = la ^ lb;
                    11: begin cond = (sa > sb); lv = cond ? mask : 64'd0; end
                    default: begin cond = (la == lb); lv = cond ? mask : 64'd0; end
                endcase
                lv = lv & mask;
                r = r | (128'(lv) << (i*w));
                if (cond)
                    for (int j = 0; j < w/8; j++) f[i*(w/8) + j] = 1'b1;
            end
        end
    endfunction

    function automatic void ref_top(input bit sp, input int sel, input int vop,
                                    input int olo, input int ohi, input int sh,
                                    input logic [127:0] a, input logic [127:0] b,
                                    output logic [127:0] r, output logic [15:0] f);
        logic [127:0] rl, rh;
        logic [15:0]  fl, fh;
        int w;
        if (sp) begin
            ref_lanes(olo, 64, 64, {64'd0, a[63:0]},   {64'd0, b[63:0]},   sh, rl, fl);
            ref_lanes(ohi, 64, 64, {64'd0, a[127:64]}, {64'd0, b[127:64]}, sh, rh, fh);
            r = {rh[63:0], rl[63:0]};
            f = {fh[7:0], fl[7:0]};
        end else begin
            w = (sel == 0) ? 8 : (sel == 1) ? 16 : 32;
            ref_lanes(vop, w, 128, a, b, sh, r, f);
        end
    endfunction

    task automatic check(input string tag, input logic [127:0] er, input logic [15:0] ef);
        nchk++;
        if (res_o !== er || flags_o !== ef) begin
            nfail++;
            $display("FAIL %s: res=%h flags=%h expected res=%h flags=%h",
                     tag, res_o, flags_o, er, ef);
        end
    endtask

    task automatic gen(input int p, output logic [127:0] a, output logic [127:0] b);
        logic [127:0] rnd;
        rnd = {$urandom, $urandom, $urandom, $urandom};
        case (p)
            0: begin a = rnd; b = {$urandom, $urandom, $urandom, $urandom}; end
            1: begin a = rnd; b = rnd; end
            2: begin a = {16{8'h80}}; b = {16{8'h7F}}; end
            3: begin a = '1; b = {16{8'h01}}; end
            4: begin a = {4{32'h8000_0000}}; b = {8{16'h8000}}; end
            default: begin a = rnd; b = '0; end
        endcase
    endtask

    task automatic run(input bit sp, input int sel, input int vop, input int olo,
                       input int ohi, input int sh, input logic [127:0] a,
                       input logic [127:0] b, input string tag);
        logic [127:0] er;
        logic [15:0]  ef;
        @(negedge clk);
        split_i = sp; lane_sel_i = 2'(sel); vec_op_i = 4'(vop);
        op_lo_i = 4'(olo); op_hi_i = 4'(ohi); shamt_i = 6'(sh);
        a_i = a; b_i = b;
        ref_top(sp, sel, vop, olo, ohi, sh, a, b, er, ef);
        @(negedge clk);
        check(tag, er, ef);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        nchk++; nfail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        logic [127:0] a, b, er1, er2;
        logic [15:0]  ef1, ef2;
        rst_n = 1'b0; split_i = 1'b0; lane_sel_i = 2'd0; vec_op_i = 4'd8;
        op_lo_i = 4'd0; op_hi_i = 4'd0; shamt_i = 6'd3;
        a_i = '1; b_i = '1;
        repeat (3) @(negedge clk);
        check("R1 reset", '0, '0);
        rst_n = 1'b1;
        check("R1 before first edge", '0, '0);

        // R2: output holds between edges, updates after one edge
        run(1'b0, 1, 0, 0, 0, 0, {8{16'h1234}}, {8{16'h0101}}, "R2 first");
        ref_top(1'b0, 1, 0, 0, 0, 0, {8{16'h1234}}, {8{16'h0101}}, er1, ef1);
        vec_op_i = 4'd10; a_i = {4{32'hDEAD_BEEF}}; b_i = '1;
        ref_top(1'b0, 1, 10, 0, 0, 0, {4{32'hDEAD_BEEF}}, '1, er2, ef2);
        #1 check("R2 hold", er1, ef1);
        @(posedge clk); #1;
        check("R2 update", er2, ef2);

        // locked sweep: every width, every opcode, boundary patterns
        for (int sel = 0; sel < 4; sel++)
            for (int op = 0; op < 16; op++)
                for (int p = 0; p < 6; p++) begin
                    gen(p, a, b);
                    run(1'b0, sel, op, 0, 0, (p * 13 + op) % 64, a, b, req_of(op));
                end

        // R11: every pair of half opcodes, lane_sel and vec_op randomised
        for (int lo = 0; lo < 16; lo++)
            for (int hi = 0; hi < 16; hi++) begin
                gen((lo + hi) % 6, a, b);
                run(1'b1, int'($urandom % 4), int'($urandom % 16), lo, hi,
                    int'($urandom % 64), a, b, "R11 split");
            end

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule